// File: doc/BRIEF.md
# Power Switch Request Handshake Unit

This block stands between logic that needs the card bus power or the I/O signalling voltage changed and the software that actually performs the change. A one-cycle pulse on any of four request lines sets a sticky pending bit. The bit stays set until software clears it. The block raises a level interrupt whenever a pending bit is also enabled in the mask register. After it has done the switch, software writes success flags to a control register. Each flag produces a one-cycle acknowledge pulse back to the requester. Both bus requests (on and off) share the bus acknowledge. Both I/O requests (low and high) share the I/O acknowledge.

The pending bits take their reset value from the `por_pend` input rather than from zero. A switch that was left half done before reset therefore appears as pending at power-on. The mask resets to zero, so software can acknowledge and clear such a leftover request before it enables the interrupt.

Each acknowledge channel has a small state machine with two states. GRP_IDLE is the resting state. GRP_PULSE drives the acknowledge high for one cycle. The transition GRP_IDLE→GRP_PULSE and the transition GRP_PULSE→GRP_PULSE are both taken on a control write that carries the channel's success flag. GRP_PULSE→GRP_IDLE is taken when no such write arrives.

Top module: `pwrsw_handshake`

## Requirements
- R1: During and after reset, before any access, the pending bits equal `por_pend`, the mask is zero, `irq` is low and both acknowledges are low.
- R2: A high on `req[i]` at a clock edge sets pending bit i at that edge. The bit assignments are: bit 0 = bus off, bit 1 = bus on, bit 2 = I/O low voltage, bit 3 = I/O high voltage.
- R3: A pending bit stays set until it is cleared; reads and writes to other registers do not change it.
- R4: A write to the clear register (offset 0xE4) clears every pending bit whose wdata bit is one. Bits written as zero are left unchanged.
- R5: When a request and a clear of the same bit fall on the same edge, the bit ends up set.
- R6: A write to the mask register (offset 0xE0) stores wdata[3:0], and a read of offset 0xE0 returns the stored value. Writing 0xF enables all four sources.
- R7: `irq` is high exactly while some pending bit is set whose mask bit is also set. A pending bit whose mask bit is clear does not raise it.
- R8: A write to the control register (offset 0xE8) with wdata[0]=1 makes `bus_ack` high for the single cycle that follows the write edge. With wdata[2]=1 it does the same for `io_ack`. Control bits 1 and 3 produce no acknowledge.
- R9: A control write with both success flags set pulses both acknowledges in the same cycle.
- R10: A read of the status register (offset 0xDC) returns the pending bits in bits [3:0]. Reads of the clear register, of unmapped offsets and of unused bits return zero. A read of the control register returns only bits 0 and 2 of the last control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| por_pend | input | 4 | Pending bits loaded during reset |
| req | input | 4 | Request pulses: bus off, bus on, I/O low, I/O high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Level interrupt |
| bus_ack | output | 1 | Bus power switch acknowledge pulse |
| io_ack | output | 1 | I/O voltage switch acknowledge pulse |

## Verification
Two things can hit the same pending bit in one cycle: a new request from the hardware side and a software clear. The bench provokes this by driving `req` on the same edge as a clear write that selects that bit and a neighbouring bit. It then reads status and expects the requested bit set and the neighbour cleared. It also fires two control writes back to back, which must hold the acknowledge high for two consecutive cycles rather than lose the second pulse.

// File: rtl/pwrsw_pkg.sv
package pwrsw_pkg;
    localparam int NREQ   = 4;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NGRP   = 2;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'hDC;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 8'hE0;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 8'hE4;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'hE8;

    typedef enum logic {
        GRP_IDLE  = 1'b0,
        GRP_PULSE = 1'b1
    } grp_state_t;

    // success flag position for acknowledge group g (bus = 0, I/O = 2)
    function automatic int succ_bit(input int g);
        return 2 * g;
    endfunction
endpackage

// File: rtl/pwrsw_status.sv
module pwrsw_status
    import pwrsw_pkg::*;
#(
    parameter int N = NREQ
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] por_pend,
    input  logic [N-1:0] req,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic         mask_we,
    input  logic [N-1:0] mask_bits,
    output logic [N-1:0] status,
    output logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] clr_eff;

    always_comb begin
        clr_eff = clr_we ? clr_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= por_pend;
            mask   <= '0;
        end else begin
            status <= (status & ~clr_eff) | req;
            if (mask_we) mask <= mask_bits;
        end
    end

    always_comb begin
        irq = |(status & mask);
    end

    AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |=> ((status & $past(req)) == $past(req))); // R2
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0 && !clr_we) |=> $stable(status)); // R3
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && req == '0) |=> ((status & $past(clr_bits)) == '0)); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && (req & clr_bits) != '0) |=> ((status & $past(req & clr_bits)) != '0)); // R5
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask)); // R6
endmodule

// File: rtl/pwrsw_ack_fsm.sv
module pwrsw_ack_fsm
    import pwrsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic ack
);
    grp_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            GRP_IDLE:  if (go) state_nx = GRP_PULSE;
            GRP_PULSE: state_nx = go ? GRP_PULSE : GRP_IDLE;
            default:   state_nx = GRP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= GRP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        ack = (state == GRP_PULSE);
    end

    AST_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(go)); // R8
    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> ack); // R8
endmodule

// File: rtl/pwrsw_handshake.sv
module pwrsw_handshake
    import pwrsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NREQ-1:0]   por_pend,
    input  logic [NREQ-1:0]   req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              bus_ack,
    output logic              io_ack
);
    logic            we_mask, we_clear, we_ctrl;
    logic [NREQ-1:0] status, mask;
    logic [NGRP-1:0] grp_go, grp_ack, ctrl_q;

    always_comb begin
        we_mask  = wr_en && (addr == OFS_MASK);
        we_clear = wr_en && (addr == OFS_CLEAR);
        we_ctrl  = wr_en && (addr == OFS_CTRL);
    end

    pwrsw_status #(.N(NREQ)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_pend  (por_pend),
        .req       (req),
        .clr_we    (we_clear),
        .clr_bits  (wdata[NREQ-1:0]),
        .mask_we   (we_mask),
        .mask_bits (wdata[NREQ-1:0]),
        .status    (status),
        .mask      (mask),
        .irq       (irq)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int SB = succ_bit(g);
        assign grp_go[g] = we_ctrl && wdata[SB];

        pwrsw_ack_fsm u_fsm (
            .clk   (clk),
            .rst_n (rst_n),
            .go    (grp_go[g]),
            .ack   (grp_ack[g])
        );

        always_ff @(posedge clk) begin
            if (!rst_n)       ctrl_q[g] <= 1'b0;
            else if (we_ctrl) ctrl_q[g] <= wdata[SB];
        end
    end

    assign bus_ack = grp_ack[0];
    assign io_ack  = grp_ack[1];

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_STATUS: rdata[NREQ-1:0] = status;
            OFS_MASK:   rdata[NREQ-1:0] = mask;
            OFS_CTRL: begin
                rdata[succ_bit(0)] = ctrl_q[0];
                rdata[succ_bit(1)] = ctrl_q[1];
            end
            default:    rdata = '0;
        endcase
    end

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq); // R7
    AST_BOTH_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_ctrl && wdata[0] && wdata[2]) |=> (bus_ack && io_ack)); // R9
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_CLEAR) |-> (rdata == '0)); // R10
endmodule

// File: tb/tb_pwrsw_handshake.sv
`timescale 1ns/1ps
module tb_pwrsw_handshake;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  por_pend = 4'b1010;
    logic [3:0]  req = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, bus_ack, io_ack;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwrsw_handshake dut (
        .clk(clk), .rst_n(rst_n), .por_pend(por_pend), .req(req),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .bus_ack(bus_ack), .io_ack(io_ack)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // drive at negedge; effect visible at the following negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] r = 4'b0);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; req = r;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; req = '0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        check(rdata === exp, tag, rdata, exp);
    endtask

    task automatic pulse_req(input logic [3:0] r);
        @(negedge clk); req = r;
        @(negedge clk); req = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rd_check(8'hDC, 32'hA, "R1 status from por_pend");
        rd_check(8'hE0, 32'h0, "R1 mask zero");
        check(irq === 1'b0 && bus_ack === 1'b0 && io_ack === 1'b0, "R1 outputs low", {irq, bus_ack, io_ack}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_check(8'hDC, 32'hA, "R1 status after release");
    endtask

    task automatic t_clear_and_set;
        wr(8'hE4, 32'h2);
        rd_check(8'hDC, 32'h8, "R4 partial clear");
        wr(8'hE4, 32'hF);
        rd_check(8'hDC, 32'h0, "R4 full clear");
        pulse_req(4'b0001);
        rd_check(8'hDC, 32'h1, "R2 bus off sets bit0");
        pulse_req(4'b0100);
        rd_check(8'hDC, 32'h5, "R2 io low sets bit2");
        wr(8'hE0, 32'h0);
        wr(8'hE8, 32'h0);
        repeat (3) @(negedge clk);
        rd_check(8'hDC, 32'h5, "R3 sticky");
        wr(8'hE4, 32'h0);
        rd_check(8'hDC, 32'h5, "R4 zero clear no effect");
    endtask

    task automatic t_set_wins;
        wr(8'hE4, 32'hF);
        pulse_req(4'b0100);
        // clear bits 2 and 3 while requesting bit 3
        wr(8'hE4, 32'hC, 4'b1000);
        rd_check(8'hDC, 32'h8, "R5 set wins over clear");
    endtask

    task automatic t_mask_irq;
        wr(8'hE4, 32'hF);
        wr(8'hE0, 32'hFFFF_FFF4);
        rd_check(8'hE0, 32'h4, "R6 mask readback low bits");
        pulse_req(4'b0010);
        check(irq === 1'b0, "R7 masked pending no irq", irq, 0);
        pulse_req(4'b0100);
        check(irq === 1'b1, "R7 unmasked pending irq", irq, 1);
        wr(8'hE4, 32'h4);
        check(irq === 1'b0, "R7 irq drops on clear", irq, 0);
        wr(8'hE0, 32'hF);
        check(irq === 1'b1, "R6 full mask enables bit1", irq, 1);
        wr(8'hE4, 32'hF);
        check(irq === 1'b0, "R7 irq low when empty", irq, 0);
    endtask

    task automatic t_acks;
        wr(8'hE8, 32'h1);
        check(bus_ack === 1'b1 && io_ack === 1'b0, "R8 bus ack pulse", {bus_ack, io_ack}, 2'b10);
        @(negedge clk);
        check(bus_ack === 1'b0, "R8 bus ack one cycle", bus_ack, 0);
        wr(8'hE8, 32'h4);
        check(io_ack === 1'b1 && bus_ack === 1'b0, "R8 io ack pulse", {bus_ack, io_ack}, 2'b01);
        @(negedge clk);
        check(io_ack === 1'b0, "R8 io ack one cycle", io_ack, 0);
        wr(8'hE8, 32'hA);
        check(bus_ack === 1'b0 && io_ack === 1'b0, "R8 bits 1,3 no ack", {bus_ack, io_ack}, 0);
        wr(8'hE8, 32'h5);
        check(bus_ack === 1'b1 && io_ack === 1'b1, "R9 both acks", {bus_ack, io_ack}, 2'b11);
        // back to back bus writes keep ack high two cycles
        @(negedge clk);
        wr_en = 1'b1; addr = 8'hE8; wdata = 32'h1;
        @(negedge clk);
        check(bus_ack === 1'b1, "R8 first of pair", bus_ack, 1);
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        check(bus_ack === 1'b1, "R8 second of pair", bus_ack, 1);
        @(negedge clk);
        check(bus_ack === 1'b0, "R8 pair ends", bus_ack, 0);
    endtask

    task automatic t_reads;
        wr(8'hE8, 32'hFFFF_FFFF);
        rd_check(8'hE8, 32'h5, "R10 ctrl readback bits 0,2");
        rd_check(8'hE4, 32'h0, "R10 clear reads zero");
        rd_check(8'h40, 32'h0, "R10 unmapped reads zero");
        pulse_req(4'b1001);
        rd_check(8'hDC, 32'h9, "R10 status upper bits zero");
    endtask

    initial begin
        t_reset();
        t_clear_and_set();
        t_set_wins();
        t_mask_irq();
        t_acks();
        t_reads();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule